// File: doc/BRIEF.md
# Clock Mask Unit with Settle Flag

This block keeps one enable mask per group of modules and turns it into per-module clock-gate enables. Each mask bit passes through a two-stage synchronizer before it reaches the gate enable, so a new mask value does not act on the gates in the cycle it is written. The block stands in for the clock-gating cells and drives synchronized enable bits only. It does not model the clock sources or the analog gating.

A status bit, `mask_ready_o`, tells software whether the gates have caught up with the mask registers. Every mask write clears it. It sets again only once the latest value has passed through the synchronizer. Software polls this bit, or takes the interrupt, before it touches a module whose clock it has just switched on. The interrupt line is the status bit gated by an enable. The enable is set and cleared through separate strobes, and a further strobe clears the status bit.

Top module: `clk_mask_unit`

## Requirements
- R1: After reset, every gate enable is 1, `mask_ready_o` is 1, the interrupt enable is off and `irq_o` is 0.
- R2: A mask value written at a clock edge appears on `gate_en_o` after the second edge that follows the write edge. Before that, the gates keep their earlier value.
- R3: Any mask write clears `mask_ready_o` from the cycle after the write edge. This holds even when the written value equals the current mask.
- R4: With no further write, `mask_ready_o` returns to 1 after the third edge that follows the write edge. At that point `gate_en_o` equals the full written mask. While the flag is 1 and no write occurs, the gates hold still.
- R5: A write made while an earlier write is still settling restarts the wait. The flag stays 0 until the third edge after the latest write.
- R6: `wr_sel_i` picks the group. Group g drives `gate_en_o[g*8 +: 8]` (group 0 is bits 7:0, group 1 is bits 15:8). A write to one group leaves the other group's gates unchanged.
- R7: A pulse on `ie_set_i` turns the interrupt enable on. `irq_o` is 1 exactly when both the enable and `mask_ready_o` are 1.
- R8: A pulse on `ie_clr_i` turns the enable off, write-one-to-clear. If `ie_set_i` and `ie_clr_i` come in the same cycle, the clear wins.
- R9: A pulse on `st_clr_i` clears `mask_ready_o`, write-one-to-clear. The flag setting at the end of a wait takes priority over a simultaneous `st_clr_i`. A mask write takes priority over both.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en_i | input | 1 | Mask write strobe |
| wr_sel_i | input | 1 | Mask group select |
| wr_data_i | input | 8 | Mask value for the selected group |
| ie_set_i | input | 1 | Interrupt enable set strobe |
| ie_clr_i | input | 1 | Interrupt enable clear strobe |
| st_clr_i | input | 1 | Status flag clear strobe |
| gate_en_o | output | 16 | Synchronized clock-gate enables, group-major |
| mask_ready_o | output | 1 | Gates match the latest written mask |
| irq_o | output | 1 | Settle interrupt |

## Verification
The mask path is tried with single writes, with repeated writes of an unchanged value, with back-to-back writes to one group, and with alternating writes across both groups. Single writes show the exact two-edge gate latency and the three-edge flag return. Unchanged-value writes show that the flag drops even when no gate moves. Back-to-back writes show that the wait restarts, and alternating writes show that the groups are independent. A long pseudo-random stretch that mixes writes with the enable and clear strobes then exposes any priority slip between those strobes, since a behavioural model is compared every cycle.

// File: rtl/cmu_pkg.sv
package cmu_pkg;
  localparam int unsigned CMU_GROUPS  = 2;
  localparam int unsigned CMU_GROUP_W = 8;
  localparam int unsigned CMU_STAGES  = 2;
endpackage

// File: rtl/cmu_rst_sync.sv
module cmu_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= 2'b00;
    else         chain_q <= {chain_q[0], 1'b1};
  end

  assign rst_no = chain_q[1];
endmodule

// File: rtl/cmu_mask_regs.sv
module cmu_mask_regs #(
  parameter int unsigned GROUPS  = 2,
  parameter int unsigned GROUP_W = 8,
  localparam int unsigned SEL_W  = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam int unsigned TOT_W  = GROUPS * GROUP_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [SEL_W-1:0]   wr_sel_i,
  input  logic [GROUP_W-1:0] wr_data_i,
  output logic [TOT_W-1:0]   mask_o
);
  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic               load;
    logic [GROUP_W-1:0] reg_q;

    assign load = wr_en_i && (wr_sel_i == SEL_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   reg_q <= '1;
      else if (load) reg_q <= wr_data_i;
    end

    assign mask_o[g*GROUP_W +: GROUP_W] = reg_q;
  end
endmodule

// File: rtl/cmu_bit_sync.sv
module cmu_bit_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = d_i;
    end else begin : g_rest
      assign stage_d = stage_q[s-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '1;
      else         stage_q[s] <= stage_d;
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/cmu_ready_ctrl.sv
module cmu_ready_ctrl #(
  parameter int unsigned TOT_W  = 16,
  parameter int unsigned STAGES = 2,
  localparam int unsigned CNT_W = $clog2(STAGES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             ie_set_i,
  input  logic             ie_clr_i,
  input  logic             st_clr_i,
  input  logic [TOT_W-1:0] mask_i,
  input  logic [TOT_W-1:0] gate_i,
  output logic             ready_o,
  output logic             ien_o
);
  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rdy_q, rdy_d;
  logic             ien_q, ien_d;
  logic             match;

  assign match = (gate_i == mask_i);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    rdy_d  = rdy_q;
    if (wr_en_i) begin
      busy_d = 1'b1;
      cnt_d  = CNT_W'(STAGES);
      rdy_d  = 1'b0;
    end else if (busy_q) begin
      if (cnt_q != '0) begin
        cnt_d = cnt_q - CNT_W'(1);
      end else if (match) begin
        rdy_d  = 1'b1;
        busy_d = 1'b0;
      end
    end else if (st_clr_i) begin
      rdy_d = 1'b0;
    end
  end

  always_comb begin
    ien_d = ien_q;
    if (ie_clr_i)      ien_d = 1'b0;
    else if (ie_set_i) ien_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      rdy_q  <= 1'b1;
      ien_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      rdy_q  <= rdy_d;
      ien_q  <= ien_d;
    end
  end

  assign ready_o = rdy_q;
  assign ien_o   = ien_q;
endmodule

// File: rtl/clk_mask_unit.sv
module clk_mask_unit #(
  parameter int unsigned GROUPS  = cmu_pkg::CMU_GROUPS,
  parameter int unsigned GROUP_W = cmu_pkg::CMU_GROUP_W,
  parameter int unsigned STAGES  = cmu_pkg::CMU_STAGES,
  localparam int unsigned SEL_W  = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam int unsigned TOT_W  = GROUPS * GROUP_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [SEL_W-1:0]   wr_sel_i,
  input  logic [GROUP_W-1:0] wr_data_i,
  input  logic               ie_set_i,
  input  logic               ie_clr_i,
  input  logic               st_clr_i,
  output logic [TOT_W-1:0]   gate_en_o,
  output logic               mask_ready_o,
  output logic               irq_o
);
  logic             rst_n_sync;
  logic [TOT_W-1:0] mask_q;
  logic             ien;

  cmu_rst_sync u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_n_sync)
  );

  cmu_mask_regs #(.GROUPS(GROUPS), .GROUP_W(GROUP_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_sync),
    .wr_en_i  (wr_en_i),
    .wr_sel_i (wr_sel_i),
    .wr_data_i(wr_data_i),
    .mask_o   (mask_q)
  );

  cmu_bit_sync #(.W(TOT_W), .STAGES(STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_n_sync),
    .d_i   (mask_q),
    .q_o   (gate_en_o)
  );

  cmu_ready_ctrl #(.TOT_W(TOT_W), .STAGES(STAGES)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_sync),
    .wr_en_i (wr_en_i),
    .ie_set_i(ie_set_i),
    .ie_clr_i(ie_clr_i),
    .st_clr_i(st_clr_i),
    .mask_i  (mask_q),
    .gate_i  (gate_en_o),
    .ready_o (mask_ready_o),
    .ien_o   (ien)
  );

  assign irq_o = mask_ready_o & ien;
endmodule

// File: rtl/cmu_chk.sv
module cmu_chk #(
  parameter int unsigned TOT_W = 16
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic             wr_en_i,
  input logic             ie_clr_i,
  input logic [TOT_W-1:0] mask_q,
  input logic [TOT_W-1:0] gate_en_o,
  input logic             mask_ready_o,
  input logic             irq_o
);
  // R3
  write_drops_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    wr_en_i |=> !mask_ready_o);

  // R4
  ready_rise_settled_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(mask_ready_o) |-> (gate_en_o == mask_q));

  // R4
  ready_gates_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (mask_ready_o && !wr_en_i) |=> $stable(gate_en_o));

  // R7
  irq_needs_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq_o |-> mask_ready_o);

  // R8
  ien_clear_kills_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    ie_clr_i |=> !irq_o);
endmodule

bind clk_mask_unit cmu_chk #(.TOT_W(TOT_W)) u_cmu_chk (
  .clk_i       (clk_i),
  .rst_n       (rst_n_sync),
  .wr_en_i     (wr_en_i),
  .ie_clr_i    (ie_clr_i),
  .mask_q      (mask_q),
  .gate_en_o   (gate_en_o),
  .mask_ready_o(mask_ready_o),
  .irq_o       (irq_o)
);

// File: tb/clk_mask_unit_bench.sv
module clk_mask_unit_bench;
  logic        clk, rst_ni;
  logic        wr_en, wr_sel, ie_set, ie_clr, st_clr;
  logic [7:0]  wr_data;
  logic [15:0] gate_en;
  logic        ready, irq;

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_req = "R1";

  clk_mask_unit u_clk_mask_unit (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .ie_set_i(ie_set), .ie_clr_i(ie_clr), .st_clr_i(st_clr),
    .gate_en_o(gate_en), .mask_ready_o(ready), .irq_o(irq)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  // behavioural reference
  logic [7:0]  m_mask [2];
  logic [15:0] m_s1, m_gate;
  logic        m_ready, m_ien;
  int          m_left;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_mask[0] <= 8'hFF; m_mask[1] <= 8'hFF;
      m_s1 <= 16'hFFFF; m_gate <= 16'hFFFF;
      m_ready <= 1'b1; m_ien <= 1'b0; m_left <= -1;
    end else begin
      m_gate <= m_s1;
      m_s1   <= {m_mask[1], m_mask[0]};
      if (wr_en) m_mask[wr_sel] <= wr_data;
      if (wr_en) begin m_ready <= 1'b0; m_left <= 2; end
      else if (m_left > 0) m_left <= m_left - 1;
      else if (m_left == 0) begin m_ready <= 1'b1; m_left <= -1; end
      else if (st_clr) m_ready <= 1'b0;
      if (ie_clr) m_ien <= 1'b0;
      else if (ie_set) m_ien <= 1'b1;
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      chk(cur_req, "gate_en", {16'd0, gate_en}, {16'd0, m_gate});
      chk(cur_req, "ready", {31'd0, ready}, {31'd0, m_ready});
      chk(cur_req, "irq", {31'd0, irq}, {31'd0, m_ready & m_ien});
    end
  end

  task automatic idle();
    wr_en = 0; wr_sel = 0; wr_data = 0; ie_set = 0; ie_clr = 0; st_clr = 0;
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write(logic sel, logic [7:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
    step(1);
    idle();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] lfsr;
    idle();
    rst_ni = 0;
    step(5);
    rst_ni = 1;
    step(4);
    // R1
    chk("R1", "reset gates", {16'd0, gate_en}, 32'h0000FFFF);
    chk("R1", "reset ready", {31'd0, ready}, 32'd1);
    chk("R1", "reset irq", {31'd0, irq}, 32'd0);

    // R2 / R3 / R4 single write to group 0
    cur_req = "R2";
    write(0, 8'h5A);                       // at n1
    chk("R3", "ready after write", {31'd0, ready}, 32'd0);
    chk("R2", "gates one edge later", {16'd0, gate_en}, 32'h0000FFFF);
    step(1);
    chk("R2", "gates two edges later (pre)", {16'd0, gate_en}, 32'h0000FFFF);
    step(1);
    chk("R2", "gates landed", {16'd0, gate_en}, 32'h0000FF5A);
    chk("R4", "ready still low", {31'd0, ready}, 32'd0);
    step(1);
    chk("R4", "ready back", {31'd0, ready}, 32'd1);

    // R6 group 1
    cur_req = "R6";
    write(1, 8'h3C);
    step(2);
    chk("R6", "group layout", {16'd0, gate_en}, 32'h00003C5A);
    step(1);

    // R3 same value write
    cur_req = "R3";
    write(1, 8'h3C);
    chk("R3", "same value clears", {31'd0, ready}, 32'd0);
    step(2);
    chk("R3", "gates unchanged", {16'd0, gate_en}, 32'h00003C5A);
    step(1);
    chk("R4", "ready after same value", {31'd0, ready}, 32'd1);

    // R5 restart
    cur_req = "R5";
    write(0, 8'h11);
    write(0, 8'h22);
    step(1);
    chk("R5", "no early ready", {31'd0, ready}, 32'd0);
    step(1);
    chk("R5", "latest value", {16'd0, gate_en}, 32'h00003C22);
    chk("R5", "still waiting", {31'd0, ready}, 32'd0);
    step(1);
    chk("R5", "ready after latest", {31'd0, ready}, 32'd1);

    // R7 / R8
    cur_req = "R7";
    ie_set = 1; step(1); idle();
    chk("R7", "irq on", {31'd0, irq}, 32'd1);
    cur_req = "R8";
    ie_clr = 1; step(1); idle();
    chk("R8", "irq off", {31'd0, irq}, 32'd0);
    ie_set = 1; ie_clr = 1; step(1); idle();
    chk("R8", "clear wins", {31'd0, irq}, 32'd0);
    ie_set = 1; step(1); idle();

    // R9
    cur_req = "R9";
    st_clr = 1; step(1); idle();
    chk("R9", "status cleared", {31'd0, ready}, 32'd0);
    chk("R9", "irq follows", {31'd0, irq}, 32'd0);
    write(1, 8'hA5);
    step(2);
    st_clr = 1; step(1); idle();
    chk("R9", "set beats clear", {31'd0, ready}, 32'd1);
    chk("R7", "irq with ready", {31'd0, irq}, 32'd1);
    wr_en = 1; wr_sel = 0; wr_data = 8'h00; st_clr = 1; step(1); idle();
    chk("R9", "write wins", {31'd0, ready}, 32'd0);
    step(3);

    // mixed pseudo-random traffic
    cur_req = "R5";
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      wr_en  = (lfsr[2:0] == 3'd0);
      wr_sel = lfsr[3];
      wr_data = lfsr[11:4];
      ie_set = (lfsr[14:12] == 3'd1);
      ie_clr = (lfsr[14:12] == 3'd2);
      st_clr = (lfsr[15:13] == 3'd3);
      step(1);
    end
    idle();
    step(4);
    finish_run();
  end
endmodule